// File: doc/BRIEF.md
# Two-Port Interrupt Aggregation Controller

This block collects event lines from two storage ports and folds them into a single level-sensitive interrupt for the host. Each port keeps a sticky status byte and an enable-inverse mask byte. A port is pending when any status bit is set and its mask bit is clear. The host level combines the port pending flags with a software-raised interrupt bit under a second mask. It then forms a global pending bit, which a control bit can keep off the interrupt line.

Software reaches every register through a 16-bit register bus with two byte enables. It reads the status, clears events by writing ones, and tunes the masks. A control bit starts a soft reset of the interrupt state that ends by itself after a fixed number of clocks. All reads are combinational from the current address.

Top module: `irqagg_ctrl`

## Requirements
- R1: After the reset input, every port status reads 0, every port mask reads 0x3F, the host mask reads 0xFFFF, control and host status read 0, and `irq_o` is low.
- R2: An event input bit held high at a clock edge sets the matching port status bit, which then stays set until cleared. Port status bit positions are: 0 removed, 1 attached, 2 completion, 3 fatal, 4 device interrupt, 5 reply queue not empty.
- R3: Port status bit 7 reads as the OR of (status AND NOT mask) over bits 5..0. A masked event is still recorded in status. Mask bits 7..6 do not exist and read 0.
- R4: Writing 1 to a port status bit clears it, writing 0 leaves it, and writing 0xFF clears every event of that port.
- R5: When an event input and a clearing write hit the same status bit at the same edge, the bit stays set.
- R6: Host status bit i (i = 0, 1) is port i pending AND NOT host mask bit i. Bit 14 is a software interrupt written directly. Bit 15 is the read-only OR of bits 0, 1 and bit 14 AND NOT host mask bit 14.
- R7: Port status is the upper byte of the halfword at port base + 0x08, and port mask is the lower byte at port base + 0x0A. Ports are spaced 0x40 apart. Control, host status and host mask are halfwords at 0x7C, 0xBC and 0xBE. Only byte lanes whose enable is high are written.
- R8: `irq_o` equals host status bit 15 AND NOT control bit 8, and it follows a register change in the same cycle.
- R9: Writing 1 to control bit 13 makes that bit read 1 for exactly 3 cycles after the write edge, after which it reads 0.
- R10: A soft reset clears all port status bits and the software interrupt bit. It sets all port mask bits and all host mask bits to 1.
- R11: Control bits other than bit 13, including bit 15, are plain storage and keep their value through a soft reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_in | input | 12 | Event lines, port p at bits [6p+5:6p] |
| bus_addr | input | 8 | Register byte address (bit 0 ignored, halfword access) |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte enables, bit 1 for data[15:8] |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed halfword, combinational |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
Every register update, whether a write, an event capture or a soft reset step, lands at the clock edge where the stimulus is sampled. Because the read path and `irq_o` are combinational, each result is due in the first half-cycle after that edge. The driver applies stimulus at falling edges and queues the expected read word and interrupt level. The monitor compares them two time units after the next falling edge, so each comparison sees exactly one edge's worth of change. The soft reset window is checked on three consecutive cycles after the write edge, followed by the cycle in which the busy bit must drop.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

   localparam int unsigned BUS_W       = 16;
   localparam int unsigned HBIT_SOFT   = 14;
   localparam int unsigned HBIT_GLOBAL = 15;
   localparam int unsigned CBIT_IRQOFF = 8;
   localparam int unsigned CBIT_SRST   = 13;

   // place a byte on the selected lane of a halfword
   function automatic logic [15:0] lane_put(input logic lane, input logic [7:0] b);
      return lane ? {b, 8'h00} : {8'h00, b};
   endfunction

   // take the byte on the selected lane of a halfword
   function automatic logic [7:0] lane_get(input logic lane, input logic [15:0] w);
      return lane ? w[15:8] : w[7:0];
   endfunction

   // byte-enable merge of new data over old
   function automatic logic [15:0] be_merge(input logic [15:0] old_v,
                                            input logic [15:0] new_v,
                                            input logic [1:0]  be);
      return {be[1] ? new_v[15:8] : old_v[15:8],
              be[0] ? new_v[7:0]  : old_v[7:0]};
   endfunction

endpackage

// File: rtl/irqagg_port.sv
module irqagg_port #(
   parameter int unsigned EVT_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             soft_clr,
   input  logic [EVT_W-1:0] ev_in,
   input  logic             st_wr,
   input  logic [EVT_W-1:0] st_wbits,
   input  logic             mk_wr,
   input  logic [EVT_W-1:0] mk_wbits,
   output logic [EVT_W-1:0] st_q,
   output logic [EVT_W-1:0] mk_q,
   output logic             pend_o
);

   generate
      if (EVT_W < 1 || EVT_W > 7) begin : g_bad_evt_w
         $error("irqagg_port: EVT_W must leave bit 7 free for the pending flag");
      end
   endgenerate

   logic [EVT_W-1:0] clr_bits;

   assign clr_bits = st_wr ? st_wbits : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q <= '0;
         mk_q <= '1;
      end else if (soft_clr) begin
         st_q <= '0;
         mk_q <= '1;
      end else begin
         st_q <= (st_q & ~clr_bits) | ev_in;
         if (mk_wr) mk_q <= mk_wbits;
      end
   end

   assign pend_o = |(st_q & ~mk_q);

   // R4: a cleared bit without a same-edge event is gone afterwards
   a_r4_clear_takes: assert property (@(posedge clk) disable iff (rst)
      ((clr_bits & ~ev_in) != '0 && !soft_clr)
      |=> ((st_q & $past(clr_bits & ~ev_in)) == '0));

   // R5: an event always lands, even against a clearing write
   a_r5_event_kept: assert property (@(posedge clk) disable iff (rst)
      (ev_in != '0 && !soft_clr)
      |=> ((st_q & $past(ev_in)) == $past(ev_in)));

   // R10: soft reset leaves status empty and mask saturated
   a_r10_port_wiped: assert property (@(posedge clk) disable iff (rst)
      soft_clr |=> (st_q == '0 && (&mk_q)));

endmodule

// File: rtl/irqagg_srst.sv
module irqagg_srst #(
   parameter int unsigned CYCLES = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic busy
);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("irqagg_srst: CYCLES must be at least 1");
      end
   endgenerate

   localparam int unsigned CW = $clog2(CYCLES + 1);
   localparam int unsigned RW = $clog2(CYCLES + 2);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                 cnt_q <= '0;
      else if (start && !busy) cnt_q <= CW'(CYCLES);
      else if (busy)           cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   // checker: length of the busy window
   logic [RW-1:0] run_q;
   always_ff @(posedge clk) begin
      if (rst)       run_q <= '0;
      else if (busy) run_q <= run_q + 1'b1;
      else           run_q <= '0;
   end

   // R9: a start from idle opens the window on the next cycle
   a_r9_starts: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> busy);

   // R9: the window is exactly CYCLES long
   a_r9_window_len: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> (run_q == RW'(CYCLES)));

endmodule

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
   import irqagg_pkg::*;
#(
   parameter int unsigned NUM_PORTS   = 2,
   parameter int unsigned EVT_W       = 6,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned PORT_STRIDE = 64,
   parameter int unsigned ST_OFF      = 9,
   parameter int unsigned MK_OFF      = 10,
   parameter int unsigned CTL_ADDR    = 124,
   parameter int unsigned HST_ADDR    = 188,
   parameter int unsigned HMK_ADDR    = 190,
   parameter int unsigned SRST_CYCLES = 3
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_PORTS*EVT_W-1:0] ev_in,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic                       bus_wr,
   input  logic [1:0]                 bus_be,
   input  logic [15:0]                bus_wdata,
   output logic [15:0]                bus_rdata,
   output logic                       irq_o
);

   localparam int unsigned STRIDE_W = $clog2(PORT_STRIDE);
   localparam int unsigned SEL_W    = ADDR_W - STRIDE_W;
   localparam logic [STRIDE_W-1:0] ST_O  = STRIDE_W'(ST_OFF);
   localparam logic [STRIDE_W-1:0] MK_O  = STRIDE_W'(MK_OFF);
   localparam logic                ST_LANE = ST_O[0];
   localparam logic                MK_LANE = MK_O[0];
   localparam logic [ADDR_W-1:0]   CTL_A = ADDR_W'(CTL_ADDR);
   localparam logic [ADDR_W-1:0]   HST_A = ADDR_W'(HST_ADDR);
   localparam logic [ADDR_W-1:0]   HMK_A = ADDR_W'(HMK_ADDR);

   generate
      if (NUM_PORTS < 1 || NUM_PORTS > 14) begin : g_bad_ports
         $error("irqagg_ctrl: NUM_PORTS must fit below the software bit");
      end
      if ((1 << STRIDE_W) != PORT_STRIDE || STRIDE_W >= ADDR_W) begin : g_bad_stride
         $error("irqagg_ctrl: PORT_STRIDE must be a power of two inside the map");
      end
      if (NUM_PORTS > (1 << SEL_W)) begin : g_bad_map
         $error("irqagg_ctrl: too many ports for the address width");
      end
      if (ST_OFF >= PORT_STRIDE || MK_OFF >= PORT_STRIDE) begin : g_bad_off
         $error("irqagg_ctrl: port register offsets exceed the stride");
      end
   endgenerate

   logic addr_lsb_unused;
   assign addr_lsb_unused = bus_addr[0];

   // ---------------- host-level decode ----------------
   logic ctl_hit, hst_hit, hmk_hit;
   logic ctl_wr, hst_wr, hmk_wr;

   assign ctl_hit = (bus_addr[ADDR_W-1:1] == CTL_A[ADDR_W-1:1]);
   assign hst_hit = (bus_addr[ADDR_W-1:1] == HST_A[ADDR_W-1:1]);
   assign hmk_hit = (bus_addr[ADDR_W-1:1] == HMK_A[ADDR_W-1:1]);
   assign ctl_wr  = bus_wr & ctl_hit;
   assign hst_wr  = bus_wr & hst_hit;
   assign hmk_wr  = bus_wr & hmk_hit;

   // ---------------- soft reset sequencer ----------------
   logic srst_start, srst_busy, soft_clr;

   assign srst_start = ctl_wr & bus_be[1] & bus_wdata[CBIT_SRST];
   assign soft_clr   = srst_start | srst_busy;

   irqagg_srst #(.CYCLES(SRST_CYCLES)) u_srst (
      .clk   (clk),
      .rst   (rst),
      .start (srst_start),
      .busy  (srst_busy)
   );

   // ---------------- per-port registers ----------------
   logic [NUM_PORTS-1:0] st_hit, mk_hit, pend_vec;
   logic [7:0]           st_rd [NUM_PORTS];
   logic [7:0]           mk_rd [NUM_PORTS];
   logic [7:0]           st_wbyte, mk_wbyte;

   assign st_wbyte = lane_get(ST_LANE, bus_wdata);
   assign mk_wbyte = lane_get(MK_LANE, bus_wdata);

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic             sel;
      logic [EVT_W-1:0] st_q, mk_q;

      assign sel       = (bus_addr[ADDR_W-1:STRIDE_W] == SEL_W'(p));
      assign st_hit[p] = sel && (bus_addr[STRIDE_W-1:1] == ST_O[STRIDE_W-1:1]);
      assign mk_hit[p] = sel && (bus_addr[STRIDE_W-1:1] == MK_O[STRIDE_W-1:1]);

      irqagg_port #(.EVT_W(EVT_W)) u_port (
         .clk      (clk),
         .rst      (rst),
         .soft_clr (soft_clr),
         .ev_in    (ev_in[p*EVT_W +: EVT_W]),
         .st_wr    (bus_wr & st_hit[p] & bus_be[ST_LANE]),
         .st_wbits (st_wbyte[EVT_W-1:0]),
         .mk_wr    (bus_wr & mk_hit[p] & bus_be[MK_LANE]),
         .mk_wbits (mk_wbyte[EVT_W-1:0]),
         .st_q     (st_q),
         .mk_q     (mk_q),
         .pend_o   (pend_vec[p])
      );

      always_comb begin
         st_rd[p]            = '0;
         st_rd[p][EVT_W-1:0] = st_q;
         st_rd[p][7]         = pend_vec[p];
         mk_rd[p]            = '0;
         mk_rd[p][EVT_W-1:0] = mk_q;
      end
   end

   // ---------------- host registers ----------------
   logic [15:0] ctl_q, hmask_q;
   logic        soft_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_q <= '0;
      end else if (ctl_wr) begin
         ctl_q            <= be_merge(ctl_q, bus_wdata, bus_be);
         ctl_q[CBIT_SRST] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hmask_q <= '1;
         soft_q  <= 1'b0;
      end else if (soft_clr) begin
         hmask_q <= '1;
         soft_q  <= 1'b0;
      end else begin
         if (hmk_wr)              hmask_q <= be_merge(hmask_q, bus_wdata, bus_be);
         if (hst_wr && bus_be[1]) soft_q  <= bus_wdata[HBIT_SOFT];
      end
   end

   // ---------------- aggregation ----------------
   logic [NUM_PORTS-1:0] host_bits;
   logic                 global_pend;
   logic [15:0]          hst_view, ctl_view;

   assign host_bits   = pend_vec & ~hmask_q[NUM_PORTS-1:0];
   assign global_pend = (|host_bits) | (soft_q & ~hmask_q[HBIT_SOFT]);

   always_comb begin
      hst_view                  = '0;
      hst_view[NUM_PORTS-1:0]   = host_bits;
      hst_view[HBIT_SOFT]       = soft_q;
      hst_view[HBIT_GLOBAL]     = global_pend;
      ctl_view                  = ctl_q;
      ctl_view[CBIT_SRST]       = srst_busy;
   end

   assign irq_o = global_pend & ~ctl_q[CBIT_IRQOFF];

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (st_hit[p]) bus_rdata = lane_put(ST_LANE, st_rd[p]);
         if (mk_hit[p]) bus_rdata = lane_put(MK_LANE, mk_rd[p]);
      end
      if (ctl_hit) bus_rdata = ctl_view;
      if (hst_hit) bus_rdata = hst_view;
      if (hmk_hit) bus_rdata = hmask_q;
   end

   // R8: setting the disable bit silences the line on the next cycle
   a_r8_off_silences: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && bus_be[1] && bus_wdata[CBIT_IRQOFF]) |=> !irq_o);

   // R6: the line only rises from a port pending flag or the software bit
   a_r6_irq_has_source: assert property (@(posedge clk) disable iff (rst)
      irq_o |-> (soft_q || (|pend_vec)));

   // R10: soft reset saturates the host mask and drops the software bit
   a_r10_host_wiped: assert property (@(posedge clk) disable iff (rst)
      soft_clr |=> ((&hmask_q) && !soft_q));

   // R11: control storage is untouched by the reset window
   a_r11_ctl_kept: assert property (@(posedge clk) disable iff (rst)
      (srst_busy && !ctl_wr) |=> $stable(ctl_q));

endmodule

// File: tb/irqagg_ctrl_test.sv
module irqagg_ctrl_test;

   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] ev_in = '0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_be = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   typedef struct {
      logic [7:0]  a;
      logic [15:0] d;
      logic        irq;
      string       tag;
   } exp_t;

   exp_t exp_q[$];

   irqagg_ctrl uut (
      .clk       (clk),
      .rst       (rst),
      .ev_in     (ev_in),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_be    (bus_be),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   always #(CLK_NS/2) clk = ~clk;

   // monitor: compare queued expectations shortly after each falling edge
   always begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
         exp_t it;
         it = exp_q.pop_front();
         total++;
         if (bus_rdata !== it.d || irq_o !== it.irq) begin
            bad++;
            $display("FAIL %s @%02h: rdata=%04h irq=%b expected rdata=%04h irq=%b",
                     it.tag, it.a, bus_rdata, irq_o, it.d, it.irq);
         end
      end
   end

   task automatic chk(input logic [7:0] a, input logic [15:0] d,
                      input logic irq, input string tag);
      exp_t it;
      bus_addr = a;
      it.a = a; it.d = d; it.irq = irq; it.tag = tag;
      exp_q.push_back(it);
      wait (exp_q.size() == 0);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [1:0] be,
                     input logic [15:0] d);
      bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic pulse(input logic [11:0] v);
      ev_in = v;
      @(negedge clk);
      ev_in = '0;
   endtask

   task automatic wr_pulse(input logic [7:0] a, input logic [1:0] be,
                           input logic [15:0] d, input logic [11:0] v);
      ev_in = v;
      bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = '0; ev_in = '0;
   endtask

   initial begin
      #(CLK_NS * 50000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not complete");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1 reset state
      chk(8'h08, 16'h0000, 1'b0, "R1 port0 status");
      chk(8'h0A, 16'h003F, 1'b0, "R1 port0 mask");
      chk(8'h48, 16'h0000, 1'b0, "R1 port1 status");
      chk(8'hBE, 16'hFFFF, 1'b0, "R1 host mask");
      chk(8'h7C, 16'h0000, 1'b0, "R1 control");
      chk(8'hBC, 16'h0000, 1'b0, "R1 host status");

      // R2/R3 masked completion event still recorded
      pulse(12'h004);
      chk(8'h08, 16'h0400, 1'b0, "R2 completion recorded while masked");

      // R3 unmask port 0
      wr(8'h0A, 2'b01, 16'h0000);
      chk(8'h0A, 16'h0000, 1'b0, "R3 mask readback");
      chk(8'h08, 16'h8400, 1'b0, "R3 pending bit7");
      chk(8'hBC, 16'h0000, 1'b0, "R6 host mask blocks port0");

      // R6 open host mask for both ports
      wr(8'hBE, 2'b11, 16'hFFFC);
      chk(8'hBC, 16'h8001, 1'b1, "R6 port0 to host bit0 and global");

      // R7 upper lane write to mask halfword does not touch mask
      wr(8'h0A, 2'b10, 16'h00FF);
      chk(8'h0A, 16'h0000, 1'b1, "R7 disabled lane ignored");

      // R8 global disable
      wr(8'h7C, 2'b10, 16'h0100);
      chk(8'hBC, 16'h8001, 1'b0, "R8 disable gates irq");
      chk(8'h7C, 16'h0100, 1'b0, "R8 control readback");
      wr(8'h7C, 2'b10, 16'h0000);
      chk(8'hBC, 16'h8001, 1'b1, "R8 irq back after enable");

      // R4 write-one-to-clear
      wr(8'h08, 2'b10, 16'h0000);
      chk(8'h08, 16'h8400, 1'b1, "R4 zero write no effect");
      wr(8'h08, 2'b10, 16'h0400);
      chk(8'h08, 16'h0000, 1'b0, "R4 one clears");
      chk(8'hBC, 16'h0000, 1'b0, "R6 host idle after clear");

      // R3/R6 port 1 with fatal masked
      wr(8'h4A, 2'b01, 16'h0008);
      pulse(12'h240);
      chk(8'h48, 16'h8900, 1'b1, "R3 port1 pending");
      chk(8'hBC, 16'h8002, 1'b1, "R6 port1 to host bit1");
      wr(8'h48, 2'b10, 16'h0100);
      chk(8'h48, 16'h0800, 1'b0, "R3 only masked bit left");
      chk(8'hBC, 16'h0000, 1'b0, "R6 host clear with masked only");
      wr(8'h48, 2'b10, 16'hFF00);
      chk(8'h48, 16'h0000, 1'b0, "R4 0xFF clears all");

      // R5 event versus clear at the same edge
      pulse(12'h012);
      chk(8'h08, 16'h9200, 1'b1, "R5 setup");
      wr_pulse(8'h08, 2'b10, 16'h1200, 12'h010);
      chk(8'h08, 16'h9000, 1'b1, "R5 event wins over clear");
      wr(8'h08, 2'b10, 16'hFF00);
      chk(8'h08, 16'h0000, 1'b0, "R4 clear after R5");

      // R6 software interrupt bit
      wr(8'hBC, 2'b10, 16'h4000);
      chk(8'hBC, 16'h4000, 1'b0, "R6 soft bit masked");
      wr(8'hBE, 2'b11, 16'hBFFC);
      chk(8'hBC, 16'hC000, 1'b1, "R6 soft bit unmasked");
      wr(8'hBC, 2'b10, 16'h8000);
      chk(8'hBC, 16'h0000, 1'b0, "R6 global bit not writable");
      wr(8'hBC, 2'b10, 16'h4000);
      chk(8'hBC, 16'hC000, 1'b1, "R6 soft bit set again");

      // R9/R10/R11 soft reset
      pulse(12'h001);
      chk(8'h08, 16'h8100, 1'b1, "R10 setup");
      wr(8'h7C, 2'b11, 16'h0042);
      chk(8'h7C, 16'h0042, 1'b1, "R11 control storage");
      wr(8'h7C, 2'b10, 16'hA000);
      chk(8'h7C, 16'hA042, 1'b0, "R9 busy cycle 1");
      chk(8'h7C, 16'hA042, 1'b0, "R9 busy cycle 2");
      chk(8'h7C, 16'hA042, 1'b0, "R9 busy cycle 3");
      chk(8'h7C, 16'h8042, 1'b0, "R9 self clear and R11 bits kept");
      chk(8'h08, 16'h0000, 1'b0, "R10 status wiped");
      chk(8'h0A, 16'h003F, 1'b0, "R10 port mask set");
      chk(8'h4A, 16'h003F, 1'b0, "R10 port1 mask set");
      chk(8'hBE, 16'hFFFF, 1'b0, "R10 host mask set");
      chk(8'hBC, 16'h0000, 1'b0, "R10 soft bit cleared");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule